// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns one of several source tick streams into a clock-enable pulse train whose average period is a fractional multiple of the source period. The ratio is N + b/a. N is the integer part. The fraction is a numerator b over a denominator a. An accumulator spreads the fraction: it lengthens some output periods by one source tick, so that over a output periods exactly a·N + b source ticks are used.

Each source is presented to the block as a single-cycle tick on one bit of `src_tick`. A registered select code chooses which tick stream is counted, and code 0 stops the output. The configuration (select code, N, b, a) is written through a load strobe. While the divider is running, new settings are held back until the current output period finishes, so a period in progress is never cut short. A gating input can freeze the divider and silence the output at any time. Its registered value can be read back.

Top module: `fracclk_div`

## Requirements
- R1: With 0 < b < a, any a consecutive output periods that start from the second period after a configuration is applied add up to exactly a·N + b selected source ticks.
- R2: After a configuration is applied, period 1 lasts N ticks. Period p (p ≥ 2) lasts N + floor((p−1)·b/a) − floor((p−2)·b/a) ticks, so every period is either N or N+1 ticks long.
- R3: When b is 0, a is 0, or b ≥ a, the fraction is ignored and every period lasts exactly N ticks.
- R4: N (`cfg_int`, 8 bits) is valid from 2 to 255, and a value of 0 or 1 is treated as 2. N = 255 with a stretched period gives 256 ticks. The fraction fields `cfg_num` (b) and `cfg_den` (a) are 6 bits each.
- R5: Select code 1 counts `src_tick[0]` (crystal), code 2 counts `src_tick[1]` (faster PLL) and code 3 counts `src_tick[2]` (slower PLL). Ticks on the bits that are not selected have no effect. Code 0 produces no pulses.
- R6: While `gate_en` is low, `div_pulse` stays low and selected ticks are not counted, so the period in progress resumes where it stopped. `gate_sts` shows the value `gate_en` had at the previous clock edge.
- R7: `cfg_load` captures all four fields. While a nonzero code is active, they take effect at the end of the current period: that period completes with the old values and the next one uses the new values as period 1. When the active code is 0, they take effect at once. A load on the same edge as a period end applies at that end.
- R8: `div_pulse` is high for exactly one clock cycle, namely the cycle after the edge that consumed the last tick of a period. Two pulses never occur in adjacent cycles.
- R9: A synchronous reset (`rst` high) clears the tick counter and the accumulator, sets the active code to 0 and `gate_sts` to 0, and holds `div_pulse` low. A period that was in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_en | input | 1 | Gating enable; low freezes the divider and forces the output low |
| gate_sts | output | 1 | Registered read-back of `gate_en` |
| cfg_sel | input | 2 | Source select code (0 off, 1 crystal, 2 faster PLL, 3 slower PLL) |
| cfg_int | input | 8 | Integer part N of the ratio |
| cfg_num | input | 6 | Fraction numerator b |
| cfg_den | input | 6 | Fraction denominator a |
| cfg_load | input | 1 | Update strobe that captures the four configuration fields |
| src_tick | input | 3 | Single-cycle ticks of the three sources, bit i for code i+1 |
| div_pulse | output | 1 | Output clock-enable pulse |

## Verification
The bench measures the length of every period in ticks and compares it against the closed-form floor sequence. A divider that adds the fraction one period early or late, or that decides on wrap with the wrong comparison, shows a one-tick shift at the first stretched period. It also fails the a·N + b window sum. The bench tries configurations with b = 0, a = 0 and b ≥ a, where a divider that does not disable the fraction would stretch periods or let its accumulator run away. It also tries N values of 0, 1 and 255, where a missing clamp would give one-tick periods and a narrow counter would wrap at 256. It issues loads in the middle of a period and on the very tick that ends one, and places resets in the middle of a period. An early apply would truncate the running period, and a lost or late apply would keep the old N for one period too many. Random ticks on the bits that are not selected, and random gating, expose a divider that counts the wrong source or keeps counting while gated off.

// File: rtl/fracclk_div.sv
module fracclk_div #(
  parameter int NW   = 8,
  parameter int FW   = 6,
  parameter int NSRC = 3,
  localparam int SW  = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gate_en,
  output logic            gate_sts,
  input  logic [SW-1:0]   cfg_sel,
  input  logic [NW-1:0]   cfg_int,
  input  logic [FW-1:0]   cfg_num,
  input  logic [FW-1:0]   cfg_den,
  input  logic            cfg_load,
  input  logic [NSRC-1:0] src_tick,
  output logic            div_pulse
);

  logic [SW-1:0] a_sel, p_sel;
  logic [NW-1:0] a_int, p_int, cnt;
  logic [FW-1:0] a_num, a_den, p_num, p_den, acc;
  logic          pend, stretch, pulse_q, gate_q, sel_tick;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (a_sel == SW'(i + 1)) sel_tick = src_tick[i];
  end

  wire          running  = a_sel != '0;
  wire          tick     = running & gate_en & sel_tick;
  wire [NW-1:0] n_eff    = (a_int < NW'(2)) ? NW'(2) : a_int;
  wire [NW-1:0] lim      = n_eff - NW'(1) + NW'(stretch);
  wire          boundary = tick & (cnt == lim);
  wire          frac_on  = (a_num != '0) & (a_den != '0) & (a_num < a_den);
  wire [FW:0]   sum      = {1'b0, acc} + {1'b0, a_num};
  wire [FW:0]   sum_less = sum - {1'b0, a_den};
  wire          wrap     = frac_on & (sum >= {1'b0, a_den});
  wire          apply    = (cfg_load | pend) & (boundary | ~running);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sel   <= '0;
      a_int   <= '0;
      a_num   <= '0;
      a_den   <= '0;
      p_sel   <= '0;
      p_int   <= '0;
      p_num   <= '0;
      p_den   <= '0;
      pend    <= 1'b0;
      cnt     <= '0;
      acc     <= '0;
      stretch <= 1'b0;
      pulse_q <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      gate_q  <= gate_en;
      pulse_q <= boundary;
      if (apply) begin
        a_sel   <= cfg_load ? cfg_sel : p_sel;
        a_int   <= cfg_load ? cfg_int : p_int;
        a_num   <= cfg_load ? cfg_num : p_num;
        a_den   <= cfg_load ? cfg_den : p_den;
        pend    <= 1'b0;
        cnt     <= '0;
        acc     <= '0;
        stretch <= 1'b0;
      end else begin
        if (cfg_load) begin
          p_sel <= cfg_sel;
          p_int <= cfg_int;
          p_num <= cfg_num;
          p_den <= cfg_den;
          pend  <= 1'b1;
        end
        if (boundary) begin
          cnt     <= '0;
          stretch <= wrap;
          if (wrap)         acc <= sum_less[FW-1:0];
          else if (frac_on) acc <= sum[FW-1:0];
          else              acc <= '0;
        end else if (tick) begin
          cnt <= cnt + NW'(1);
        end
      end
    end
  end

  assign div_pulse = pulse_q & gate_en;
  assign gate_sts  = gate_q;

endmodule

// File: rtl/fracclk_div_chk.sv
module fracclk_div_chk #(
  parameter int NW = 8,
  parameter int FW = 6,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          gate_en,
  input logic          gate_sts,
  input logic          div_pulse,
  input logic [SW-1:0] a_sel,
  input logic [FW-1:0] a_den,
  input logic [FW-1:0] acc,
  input logic [NW-1:0] cnt
);

  AST_GATE_SILENCES: assert property (@(posedge clk) disable iff (rst) !gate_en |=> !div_pulse); // R6
  AST_GATE_READBACK: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (gate_sts == $past(gate_en))); // R6
  AST_CODE_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst) ($past(a_sel) == '0) |-> !div_pulse); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) div_pulse |=> !div_pulse); // R8
  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (rst) (acc != '0) |-> (acc < a_den)); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!div_pulse && acc == '0 && cnt == '0 && a_sel == '0 && !gate_sts)); // R9

endmodule

bind fracclk_div fracclk_div_chk #(.NW(NW), .FW(FW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .gate_en(gate_en), .gate_sts(gate_sts), .div_pulse(div_pulse),
  .a_sel(a_sel), .a_den(a_den), .acc(acc), .cnt(cnt)
);

// File: tb/fracclk_div_bench.sv
`timescale 1ns/1ps
module fracclk_div_bench;
  logic clk = 1'b0, rst = 1'b1, gate_en = 1'b1, cfg_load = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_int = '0;
  logic [5:0] cfg_num = '0, cfg_den = '0;
  logic [2:0] src_tick = '0;
  logic gate_sts, div_pulse;

  int n_chk = 0, n_fail = 0, got = 0, b2b = 0;
  int plen[128];
  bit mid_arm = 0, mid_used = 0;
  int mid_per = 0, mid_tick = 0, mid_n = 0, mid_a = 0, mid_b = 0;

  always #2.5 clk = ~clk;

  fracclk_div u_fracclk_div (
    .clk(clk), .rst(rst), .gate_en(gate_en), .gate_sts(gate_sts),
    .cfg_sel(cfg_sel), .cfg_int(cfg_int), .cfg_num(cfg_num), .cfg_den(cfg_den),
    .cfg_load(cfg_load), .src_tick(src_tick), .div_pulse(div_pulse)
  );

  function automatic int exp_len(int p, int n, int a, int b);
    int ne = (n < 2) ? 2 : n;
    if (a == 0 || b == 0 || b >= a || p < 2) return ne;
    return ne + ((p - 1) * b) / a - ((p - 2) * b) / a;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_load = 1'b0; src_tick = '0; gate_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(int sel, int n, int a, int b);
    cfg_sel = 2'(sel); cfg_int = 8'(n); cfg_num = 6'(b); cfg_den = 6'(a);
    cfg_load = 1'b1; src_tick = '0;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic measure(int sel, int nper, int pct, int gpct, int limit);
    int ticks = 0;
    int cyc = 0;
    bit prev = 0;
    got = 0;
    while (got < nper && cyc < limit) begin
      logic [2:0] t;
      t = 3'($urandom);
      if (sel != 0) t[sel-1] = (($urandom % 100) < 32'(pct));
      gate_en = (($urandom % 100) < 32'(gpct));
      cfg_load = 1'b0;
      if (mid_arm && got == mid_per && ticks == mid_tick) begin
        cfg_int = 8'(mid_n); cfg_num = 6'(mid_b); cfg_den = 6'(mid_a);
        cfg_load = 1'b1; mid_arm = 0;
      end
      src_tick = t;
      if (sel != 0 && gate_en && t[sel-1]) ticks++;
      @(negedge clk);
      cyc++;
      if (div_pulse) begin
        if (prev) b2b++;
        if (got < 128) plen[got] = ticks;
        got++;
        ticks = 0;
      end
      prev = div_pulse;
    end
    src_tick = '0; gate_en = 1'b1; cfg_load = 1'b0;
  endtask

  task automatic run_case(string tag, int sel, int n, int a, int b, int nper, int pct, int gpct);
    int e;
    int s;
    do_reset();
    load(sel, n, a, b);
    measure(sel, nper, pct, gpct, nper * 600 + 200);
    chk({tag, " R8 pulse count"}, got, nper);
    for (int i = 0; i < got && i < nper; i++) begin
      if (mid_used && i > mid_per) e = exp_len(i - mid_per, mid_n, mid_a, mid_b);
      else e = exp_len(i + 1, n, a, b);
      chk($sformatf("%s R2 period %0d", tag, i + 1), plen[i], e);
    end
    if (!mid_used && a > 0 && b > 0 && b < a && got >= a + 1) begin
      s = 0;
      for (int i = 1; i <= a; i++) s += plen[i];
      chk({tag, " R1 window sum"}, s, a * ((n < 2) ? 2 : n) + b);
    end
    mid_used = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    // R9 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 pulse after reset", 32'(div_pulse), 0);
    chk("R9 gate_sts after reset", 32'(gate_sts), 0);
    // R6 read-back
    gate_en = 1'b0; @(negedge clk);
    chk("R6 gate_sts low", 32'(gate_sts), 0);
    gate_en = 1'b1; @(negedge clk);
    chk("R6 gate_sts high", 32'(gate_sts), 1);
    // R3 fraction ignored
    run_case("R3 a=0", 1, 3, 0, 5, 6, 100, 100);
    run_case("R3 b=0", 1, 7, 9, 0, 4, 70, 100);
    run_case("R3 b>=a", 1, 4, 3, 3, 6, 100, 100);
    // R2 / R1 directed
    run_case("R2 5+1/4", 1, 5, 4, 1, 9, 100, 100);
    run_case("R2 3+5/7", 1, 3, 7, 5, 10, 60, 100);
    // R4 clamp and top of range
    run_case("R4 N=0", 1, 0, 0, 0, 5, 100, 100);
    run_case("R4 N=1", 1, 1, 0, 0, 5, 100, 100);
    run_case("R4 N=255", 1, 255, 63, 62, 5, 100, 100);
    // R5 source selection
    run_case("R5 code2", 2, 6, 5, 3, 8, 80, 100);
    run_case("R5 code3", 3, 4, 3, 2, 8, 60, 100);
    do_reset();
    load(0, 3, 0, 0);
    measure(0, 1, 100, 100, 300);
    chk("R5 code 0 no pulses", got, 0);
    // R6 gating
    run_case("R6 gated", 1, 3, 5, 2, 12, 80, 70);
    // R7 load mid period and on the boundary tick
    mid_arm = 1; mid_used = 1; mid_per = 1; mid_tick = 2; mid_n = 9; mid_a = 0; mid_b = 0;
    run_case("R7 mid", 1, 5, 0, 0, 5, 100, 100);
    mid_arm = 1; mid_used = 1; mid_per = 1; mid_tick = 4; mid_n = 3; mid_a = 4; mid_b = 3;
    run_case("R7 edge", 1, 5, 0, 0, 7, 100, 100);
    // R9 reset in the middle of a period
    do_reset();
    load(1, 6, 0, 0);
    src_tick = 3'b001;
    repeat (3) @(negedge clk);
    run_case("R9 restart", 1, 6, 0, 0, 3, 100, 100);
    // random mix
    for (int k = 0; k < 20; k++) begin
      int n, a, b, sel, pct;
      n = 2 + int'($urandom % 11);
      a = int'($urandom % 64);
      b = int'($urandom % 64);
      sel = 1 + int'($urandom % 3);
      pct = 50 + int'($urandom % 51);
      run_case($sformatf("R2 rnd%0d", k), sel, n, a, b, (a + 2 > 66) ? 66 : a + 2, pct, 100);
    end
    chk("R8 adjacent pulses", b2b, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule